// File: doc/BRIEF.md
# Triple-Input Mid-Value Select Voter

This block sits at the join point of a triple-modular-redundant datapath that carries multi-bit unsigned numeric samples, such as converted sensor readings. Each of three replicated modules delivers one sample, and all three arrive together under a single valid strobe. The voter forwards the sample that lies numerically between the other two. This masks one corrupted channel even when the two healthy channels do not match bit for bit.

A bitwise majority vote fails when healthy channels differ only in their low-order bits. The median does not: two healthy channels bracket the true value, so a single outlier, high or low, can never be the middle value. The selected value is registered and appears one clock after the input strobe.

A diagnostic flag is registered alongside the output. It reports when the spread of the three samples (largest minus smallest) is greater than a threshold supplied on a port. The flag never influences which value is chosen, and it does not say which channel misbehaved.

Top module: `mid_value_voter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `out_valid`, `out_data` and `out_disagree` all at 0.
- R2: `out_valid` at the end of clock edge k equals `in_valid` sampled at edge k, so the output is valid exactly one clock after the inputs.
- R3: When the three samples are distinct, `out_data` equals the one that is greater than one and less than the other (unsigned comparison).
- R4: When two or three samples are equal, `out_data` equals that shared value.
- R5: `out_data` is always one of the three sampled inputs, and one outlier is never selected while the other two samples are close together.
- R6: `out_disagree` is 1 exactly when the accepted samples satisfy max minus min strictly greater than `thresh`; a spread equal to `thresh` gives 0. The flag is 0 whenever `out_valid` is 0.
- R7: The value of `thresh` has no effect on `out_data`.
- R8: When `in_valid` is 0 at an edge, `out_data` keeps its previous value whatever the channel inputs are.
- R9: A reset asserted in the middle of a stream of valid samples clears the outputs as in R1. Normal voting resumes on the first valid sample after the reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The three channel samples are valid this cycle |
| ch_a | input | DATA_W | Sample from replica A (unsigned) |
| ch_b | input | DATA_W | Sample from replica B (unsigned) |
| ch_c | input | DATA_W | Sample from replica C (unsigned) |
| thresh | input | DATA_W | Largest spread that is not flagged |
| out_valid | output | 1 | `out_data` holds a freshly voted value |
| out_data | output | DATA_W | Registered mid value |
| out_disagree | output | 1 | Registered diagnostic: spread above `thresh` |

## Verification
The patterns place the median in each of the three channel positions, so that a selection stuck on one channel or a swapped comparison is exposed. Equal-pair and all-equal triples exercise the tie paths of the strict comparisons. Triples with healthy channels a few LSBs apart and a full-scale outlier, both high and low, separate a true median from a bitwise majority or a min/max picker. Spreads exactly at and one above the threshold pin down the strictness of the flag. The same triple is then replayed under extreme thresholds to show that the data path ignores the threshold.

// File: rtl/mvs_pkg.sv
`timescale 1ns/1ps
package mvs_pkg;
    localparam int NUM_CH   = 3;
    localparam int NUM_PAIR = 3;

    // pair order: 0 = (A,B), 1 = (B,C), 2 = (A,C)
    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2
    } ch_sel_e;

    function automatic int pair_left(input int p);
        return (p == 1) ? 1 : 0;
    endfunction

    function automatic int pair_right(input int p);
        return (p == 0) ? 1 : 2;
    endfunction
endpackage

// File: rtl/mvs_pair_cmp.sv
`timescale 1ns/1ps
module mvs_pair_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] left_val,
    input  logic [DATA_W-1:0] right_val,
    output logic              left_gt
);
    always_comb begin
        left_gt = (left_val > right_val);
    end
endmodule

// File: rtl/mvs_median_sel.sv
`timescale 1ns/1ps
module mvs_median_sel
    import mvs_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [NUM_CH-1:0][DATA_W-1:0] chans,
    input  logic [NUM_PAIR-1:0]           gt,
    output logic [DATA_W-1:0]             mid_val,
    output logic [DATA_W-1:0]             hi_val,
    output logic [DATA_W-1:0]             lo_val
);
    logic    a_gt_b, b_gt_c, a_gt_c;
    ch_sel_e mid_sel, hi_sel, lo_sel;

    always_comb begin
        a_gt_b = gt[0];
        b_gt_c = gt[1];
        a_gt_c = gt[2];

        // B sits between A and C when both comparisons agree
        if (a_gt_b == b_gt_c) begin
            mid_sel = SEL_B;
        end else if (a_gt_b ^ a_gt_c) begin
            mid_sel = SEL_A;
        end else begin
            mid_sel = SEL_C;
        end

        if (a_gt_b) begin
            hi_sel = a_gt_c ? SEL_A : SEL_C;
            lo_sel = b_gt_c ? SEL_C : SEL_B;
        end else begin
            hi_sel = b_gt_c ? SEL_B : SEL_C;
            lo_sel = a_gt_c ? SEL_C : SEL_A;
        end
    end

    always_comb begin
        unique case (mid_sel)
            SEL_A:   mid_val = chans[0];
            SEL_B:   mid_val = chans[1];
            default: mid_val = chans[2];
        endcase
        unique case (hi_sel)
            SEL_A:   hi_val = chans[0];
            SEL_B:   hi_val = chans[1];
            default: hi_val = chans[2];
        endcase
        unique case (lo_sel)
            SEL_A:   lo_val = chans[0];
            SEL_B:   lo_val = chans[1];
            default: lo_val = chans[2];
        endcase
    end
endmodule

// File: rtl/mvs_spread_chk.sv
`timescale 1ns/1ps
module mvs_spread_chk #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] hi_val,
    input  logic [DATA_W-1:0] lo_val,
    input  logic [DATA_W-1:0] limit,
    output logic              too_wide
);
    logic [DATA_W-1:0] spread;

    always_comb begin
        spread   = hi_val - lo_val;
        too_wide = (spread > limit);
    end
endmodule

// File: rtl/mid_value_voter.sv
`timescale 1ns/1ps
module mid_value_voter
    import mvs_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] ch_a,
    input  logic [DATA_W-1:0] ch_b,
    input  logic [DATA_W-1:0] ch_c,
    input  logic [DATA_W-1:0] thresh,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_disagree
);
    logic [NUM_CH-1:0][DATA_W-1:0] chans;
    logic [NUM_PAIR-1:0]           gt;
    logic [DATA_W-1:0]             mid_val, hi_val, lo_val;
    logic                          too_wide;

    always_comb begin
        chans[0] = ch_a;
        chans[1] = ch_b;
        chans[2] = ch_c;
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        mvs_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
            .left_val  (chans[pair_left(p)]),
            .right_val (chans[pair_right(p)]),
            .left_gt   (gt[p])
        );
    end

    mvs_median_sel #(.DATA_W(DATA_W)) u_sel (
        .chans   (chans),
        .gt      (gt),
        .mid_val (mid_val),
        .hi_val  (hi_val),
        .lo_val  (lo_val)
    );

    mvs_spread_chk #(.DATA_W(DATA_W)) u_spread (
        .hi_val   (hi_val),
        .lo_val   (lo_val),
        .limit    (thresh),
        .too_wide (too_wide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_disagree <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            out_disagree <= in_valid & too_wide;
            if (in_valid) begin
                out_data <= mid_val;
            end
        end
    end
endmodule

// File: rtl/mid_value_voter_chk.sv
`timescale 1ns/1ps
module mid_value_voter_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] ch_a,
    input logic [DATA_W-1:0] ch_b,
    input logic [DATA_W-1:0] ch_c,
    input logic [DATA_W-1:0] thresh,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_disagree
);
    // R1 / R9: reset clears the registered outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && !out_disagree));

    // R2: one-cycle valid latency
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3 / R4: at least two samples at or below, and two at or above, the output
    assert_is_median_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |->
            ((int'($past(ch_a) <= out_data) + int'($past(ch_b) <= out_data)
              + int'($past(ch_c) <= out_data)) >= 2) &&
            ((int'($past(ch_a) >= out_data) + int'($past(ch_b) >= out_data)
              + int'($past(ch_c) >= out_data)) >= 2));

    // R5: output is always one of the sampled channels
    assert_from_input_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == $past(ch_a) || out_data == $past(ch_b)
                       || out_data == $past(ch_c)));

    // R6: flag only accompanies a valid output
    assert_flag_gated_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_disagree);

    // R8: data held while no new samples arrive
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    logic unused_thresh;
    always_comb unused_thresh = ^thresh;
endmodule

bind mid_value_voter mid_value_voter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .ch_a         (ch_a),
    .ch_b         (ch_b),
    .ch_c         (ch_c),
    .thresh       (thresh),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_disagree (out_disagree)
);

// File: tb/sim_mid_value_voter.sv
`timescale 1ns/1ps
module sim_mid_value_voter;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] ch_a = '0, ch_b = '0, ch_c = '0, thresh = '0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_disagree;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    int exp_valid = 0, exp_data = 0, exp_dis = 0;
    string data_req = "R3";

    always #5 clk = ~clk;

    mid_value_voter #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c), .thresh(thresh),
        .out_valid(out_valid), .out_data(out_data), .out_disagree(out_disagree)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: sort three numbers, take the middle one
    always @(posedge clk) begin
        int v[3];
        int t;
        if (rst) begin
            exp_valid = 0; exp_data = 0; exp_dis = 0;
        end else begin
            exp_valid = int'(in_valid);
            exp_dis = 0;
            if (in_valid) begin
                v[0] = int'(ch_a); v[1] = int'(ch_b); v[2] = int'(ch_c);
                for (int i = 0; i < 2; i++)
                    for (int j = 0; j < 2 - i; j++)
                        if (v[j] > v[j+1]) begin
                            t = v[j]; v[j] = v[j+1]; v[j+1] = t;
                        end
                exp_data = v[1];
                exp_dis = ((v[2] - v[0]) > int'(thresh)) ? 1 : 0;
            end
        end
    end

    // compare against the model on every clock
    always @(negedge clk) begin
        if (cycles > 2) begin
            check("R2 valid", int'(out_valid), exp_valid);
            check({data_req, " data"}, int'(out_data), exp_data);
            check("R6 flag", int'(out_disagree), exp_dis);
        end
    end

    task automatic drive(input int a, input int b, input int c, input int th, input bit v);
        @(negedge clk); #1;
        ch_a = W'(a); ch_b = W'(b); ch_c = W'(c); thresh = W'(th); in_valid = v;
    endtask

    task automatic vote(input string req, input int a, input int b, input int c,
                        input int th, input int exp_mid, input int exp_flag);
        data_req = req;
        drive(a, b, c, th, 1'b1);
        @(negedge clk);
        check(req, int'(out_data), exp_mid);
        check("R6", int'(out_disagree), exp_flag);
        check("R2", int'(out_valid), 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 data", int'(out_data), 0);
        check("R1 flag", int'(out_disagree), 0);
        #1 rst = 1'b0;

        // R3: median in each channel position
        vote("R3", 150, 200, 100, 4095, 150, 0);
        vote("R3", 4095, 2048, 0, 4095, 2048, 0);
        vote("R3", 7, 3, 5, 4095, 5, 0);
        // R4: ties
        vote("R4", 5, 5, 9, 4095, 5, 0);
        vote("R4", 9, 1, 9, 4095, 9, 0);
        vote("R4", 3, 3, 3, 0, 3, 0);
        vote("R4", 20, 8, 8, 4095, 8, 0);
        // R5: LSB-level disagreement plus one outlier
        vote("R5", 1000, 1002, 4095, 4095, 1002, 0);
        vote("R5", 1001, 0, 999, 4095, 999, 0);
        vote("R5", 4094, 2500, 2503, 4095, 2503, 0);
        // R6: spread at and above threshold
        vote("R6", 100, 110, 105, 10, 105, 0);
        vote("R6", 100, 111, 105, 10, 105, 1);
        vote("R6", 0, 4095, 4095, 4094, 4095, 1);
        // R7: threshold extremes leave data untouched
        vote("R7", 300, 700, 500, 0, 500, 1);
        vote("R7", 300, 700, 500, 4095, 500, 0);

        // R8: no valid, changing inputs, data held
        data_req = "R8";
        drive(1, 2, 3, 0, 1'b0);
        drive(4000, 4001, 4002, 0, 1'b0);
        @(negedge clk);
        check("R8 hold", int'(out_data), 500);
        check("R8 valid", int'(out_valid), 0);
        check("R8 flag", int'(out_disagree), 0);

        // R9: reset mid-stream, then recover
        data_req = "R9";
        drive(10, 30, 20, 0, 1'b1);
        @(negedge clk); #1 rst = 1'b1;
        @(negedge clk);
        check("R9 valid", int'(out_valid), 0);
        check("R9 data", int'(out_data), 0);
        #1 rst = 1'b0;
        vote("R9", 60, 40, 50, 5, 50, 1);

        drive(0, 0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule